// File: doc/BRIEF.md
# DMA Channel Interrupt Register Block

This block collects the event pulses of one DMA channel into a twelve-bit pending-event register, filters them through a mask, and drives one level-sensitive interrupt line. Software reaches it through a single-cycle 32-bit register port. Pending bits are cleared by writing ones. The mask cannot be written directly. Software changes it through two write-only ports: one unmasks bits and the other masks them.

Two 8-bit accounting counters track completed descriptors, one for the source side and one for the destination side. Each counter is cleared by reading it. When a counter wraps, it raises its own error event. An access to an offset the block does not decode raises an invalid-access event. Descriptor processing and data movement belong to the surrounding channel logic, which feeds this block with one-cycle event pulses.

Top module: `dma_irq_regs`

## Requirements
- R1: Event bit positions are: 0 invalid access, 1 source descriptor done, 2 destination descriptor done, 3 byte-count overflow, 4 source accounting error, 5 destination accounting error, 6 source descriptor read error, 7 destination descriptor read error, 8 data read error, 9 data write error, 10 transfer done, 11 pause. A high `evt_i` bit among 1–3 and 6–11 sets the matching pending bit on the next clock edge.
- R2: Writing the pending register (word offset 0x00) clears every pending bit whose write-data bit is 1 and leaves the others unchanged.
- R3: The mask register (offset 0x04) reads 0xFFF after reset. Writes to it have no effect.
- R4: A write to the unmask port (0x08) clears the mask bits whose data bits are 1. A write to the mask port (0x0C) sets them. Both ports read as zero.
- R5: `irq_o` is high exactly when some pending bit is set and its mask bit is clear, one cycle after the edge that changed either register.
- R6: The source counter (0x10) counts `evt_i[1]` pulses and the destination counter (0x14) counts `evt_i[2]` pulses. Both are read-only.
- R7: An increment from 255 wraps the counter to 0 and sets pending bit 4 (source) or bit 5 (destination).
- R8: Reading a counter returns its value and clears it to 0.
- R9: Any read or write to an offset other than 0x00–0x14 sets pending bit 0. Such a read returns zero.
- R10: When an event pulse and a write-1-to-clear hit the same pending bit in one cycle, the bit stays set.
- R11: When a counter read and an increment land in one cycle, the read returns the old value and the counter becomes 1 without a wrap event.
- R12: `evt_i` bits 0, 4 and 5 are ignored. Those pending bits are set only by the block itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| evt_i | input | 12 | Event pulses from the channel logic |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted pending or mask bit appears on `irq_o` in the cycle after the faulty edge, and on a status or mask read at any later time. A counter that drifts stays hidden until it is read or wraps. For that reason the tests drive exact pulse counts, including the full 256-step wrap, and read the counter back both directly and through the accounting-error bit. The same-cycle collisions (event against clear, increment against read) are driven deliberately, because a wrong priority there only shows as a one-count or one-bit discrepancy.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int N_EVT = 12;

  localparam int EV_BAD_ACC  = 0;
  localparam int EV_SRC_DONE = 1;
  localparam int EV_DST_DONE = 2;
  localparam int EV_SRC_ACCT = 4;
  localparam int EV_DST_ACCT = 5;

  // Pending bits the channel logic may set directly.
  localparam logic [N_EVT-1:0] EXT_EVT_MASK = 12'hFCE;

  // Word indices of the decoded registers.
  localparam int WI_STATUS = 0;
  localparam int WI_MASK   = 1;
  localparam int WI_UNMASK = 2;
  localparam int WI_DOMASK = 3;
  localparam int WI_SRCCNT = 4;
  localparam int WI_DSTCNT = 5;

  typedef enum logic [2:0] {
    RS_NONE, RS_STATUS, RS_MASK, RS_ZERO, RS_SRC, RS_DST
  } rd_sel_e;

  typedef struct packed {
    logic st_clr;
    logic unmask;
    logic domask;
    logic src_rd;
    logic dst_rd;
    logic bad_acc;
  } strobe_t;
endpackage

// File: rtl/dma_irq_rst_sync.sv
module dma_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output rd_sel_e           rsel
);
  localparam int WI_W = ADDR_W - 2;

  logic [WI_W-1:0] widx;
  logic            unused_lsb;

  assign widx       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    stb  = '0;
    rsel = RS_NONE;
    if (sel) begin
      case (widx)
        WI_W'(WI_STATUS): begin
          stb.st_clr = wr;
          rsel       = RS_STATUS;
        end
        WI_W'(WI_MASK):   rsel = RS_MASK;
        WI_W'(WI_UNMASK): begin
          stb.unmask = wr;
          rsel       = RS_ZERO;
        end
        WI_W'(WI_DOMASK): begin
          stb.domask = wr;
          rsel       = RS_ZERO;
        end
        WI_W'(WI_SRCCNT): begin
          stb.src_rd = !wr;
          rsel       = RS_SRC;
        end
        WI_W'(WI_DSTCNT): begin
          stb.dst_rd = !wr;
          rsel       = RS_DST;
        end
        default: begin
          stb.bad_acc = 1'b1;
          rsel        = RS_ZERO;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_irq_acct_cnt.sv
module dma_irq_acct_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_d;
  logic             carry;
  logic             cnt_en;

  always_comb begin
    base            = rd_clr ? '0 : cnt_q;
    {carry, cnt_d}  = {1'b0, base} + {{CNT_W{1'b0}}, inc};
    wrap            = inc & carry;
    cnt_en          = inc | rd_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_vec,
  input  logic             st_clr,
  input  logic             unmask,
  input  logic             domask,
  input  logic [N_EVT-1:0] wbits,
  output logic [N_EVT-1:0] status_q,
  output logic [N_EVT-1:0] mask_q
);
  logic [N_EVT-1:0] status_d;
  logic [N_EVT-1:0] mask_d;
  logic             st_en;
  logic             mk_en;

  always_comb begin
    status_d = (status_q & ~(st_clr ? wbits : '0)) | set_vec;
    mask_d   = (mask_q & ~(unmask ? wbits : '0)) | (domask ? wbits : '0);
    st_en    = st_clr | (|set_vec);
    mk_en    = unmask | domask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= '0;
    else if (st_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '1;
    else if (mk_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              irq_o
);
  logic             rst_sync_n;
  strobe_t          stb;
  rd_sel_e          rsel;
  logic [N_EVT-1:0] status_q;
  logic [N_EVT-1:0] mask_q;
  logic [N_EVT-1:0] set_vec;
  logic [CNT_W-1:0] cnt_q [2];
  logic [1:0]       wrap;
  logic [1:0]       cnt_inc;
  logic [1:0]       cnt_rd;
  logic [CNT_W-1:0] src_cnt;
  logic [CNT_W-1:0] dst_cnt;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:N_EVT];

  dma_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel  (bus_sel),
    .wr   (bus_wr),
    .addr (bus_addr),
    .stb  (stb),
    .rsel (rsel)
  );

  assign cnt_inc = {evt_i[EV_DST_DONE], evt_i[EV_SRC_DONE]};
  assign cnt_rd  = {stb.dst_rd, stb.src_rd};

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_irq_acct_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .inc    (cnt_inc[s]),
      .rd_clr (cnt_rd[s]),
      .cnt_q  (cnt_q[s]),
      .wrap   (wrap[s])
    );
  end

  assign src_cnt = cnt_q[0];
  assign dst_cnt = cnt_q[1];

  always_comb begin
    set_vec              = evt_i & EXT_EVT_MASK;
    set_vec[EV_BAD_ACC]  = stb.bad_acc;
    set_vec[EV_SRC_ACCT] = wrap[0];
    set_vec[EV_DST_ACCT] = wrap[1];
  end

  dma_irq_status u_st (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_vec  (set_vec),
    .st_clr   (stb.st_clr),
    .unmask   (stb.unmask),
    .domask   (stb.domask),
    .wbits    (bus_wdata[N_EVT-1:0]),
    .status_q (status_q),
    .mask_q   (mask_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (rsel)
      RS_STATUS: bus_rdata[N_EVT-1:0] = status_q;
      RS_MASK:   bus_rdata[N_EVT-1:0] = mask_q;
      RS_SRC:    bus_rdata[CNT_W-1:0] = src_cnt;
      RS_DST:    bus_rdata[CNT_W-1:0] = dst_cnt;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_o = |(status_q & ~mask_q);
endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_EVT-1:0]  evt_i,
  input logic              irq_o,
  input logic [N_EVT-1:0]  status_q,
  input logic [N_EVT-1:0]  mask_q,
  input logic [CNT_W-1:0]  src_cnt
);
  logic [ADDR_W-3:0] widx;
  logic              wr_st, wr_un, wr_dm, rd_src, bad;
  logic [N_EVT-1:0]  wb;
  logic [N_EVT-1:0]  ext_ev;

  assign widx   = bus_addr[ADDR_W-1:2];
  assign wr_st  = bus_sel && bus_wr && widx == WI_STATUS;
  assign wr_un  = bus_sel && bus_wr && widx == WI_UNMASK;
  assign wr_dm  = bus_sel && bus_wr && widx == WI_DOMASK;
  assign rd_src = bus_sel && !bus_wr && widx == WI_SRCCNT;
  assign bad    = bus_sel && widx > WI_DSTCNT;
  assign wb     = bus_wdata[N_EVT-1:0];
  assign ext_ev = evt_i & EXT_EVT_MASK;

  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_ev && !wr_st) |=> ((status_q & $past(ext_ev)) == $past(ext_ev)));

  a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_ev && wr_st) |=> ((status_q & $past(ext_ev)) == $past(ext_ev)));

  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && evt_i == '0) |=> ((status_q & $past(wb)) == '0));

  a_r4_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_un |=> ((mask_q & $past(wb)) == '0));

  a_r4_domask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dm |=> ((mask_q & $past(wb)) == $past(wb)));

  a_r5_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_o);

  a_r5_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[10] && !mask_q[10] && !wr_dm) |=> irq_o);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src && !evt_i[EV_SRC_DONE]) |=> (src_cnt == '0));

  a_r11_read_and_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src && evt_i[EV_SRC_DONE]) |=> (src_cnt == CNT_W'(1)));

  a_r9_bad_access: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> status_q[EV_BAD_ACC]);
endmodule

bind dma_irq_regs dma_irq_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt_i     (evt_i),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .src_cnt   (src_cnt)
);

// File: tb/dma_irq_regs_tb.sv
module dma_irq_regs_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [7:0] A_ST  = 8'h00;
  localparam logic [7:0] A_MK  = 8'h04;
  localparam logic [7:0] A_UN  = 8'h08;
  localparam logic [7:0] A_DM  = 8'h0C;
  localparam logic [7:0] A_SC  = 8'h10;
  localparam logic [7:0] A_DC  = 8'h14;
  localparam logic [7:0] A_BAD = 8'h40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic [11:0]       evt_i;
  logic              irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dma_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_i),
    .irq_o     (irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(logic [11:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic clean();
    logic [31:0] d;
    bw(A_ST, 32'hFFF);
    bw(A_DM, 32'hFFF);
    br(A_SC, d);
    br(A_DC, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    br(A_MK, d);  check("R3 mask after reset", d, 32'hFFF);
    br(A_ST, d);  check("R1 status after reset", d, 32'h0);
    check("R5 irq after reset", {31'b0, irq_o}, 32'h0);
    br(A_SC, d);  check("R6 src count after reset", d, 32'h0);
  endtask

  task automatic t_mask_ports();
    logic [31:0] d;
    clean();
    bw(A_MK, 32'h0);
    br(A_MK, d);  check("R3 mask write ignored", d, 32'hFFF);
    bw(A_UN, 32'h404);
    br(A_MK, d);  check("R4 unmask clears bits", d, 32'hBFB);
    br(A_UN, d);  check("R4 unmask port reads zero", d, 32'h0);
    bw(A_DM, 32'h004);
    br(A_MK, d);  check("R4 domask sets bits", d, 32'hBFF);
    br(A_DM, d);  check("R4 domask port reads zero", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    clean();
    pulse(12'h400);
    check("R5 masked event keeps irq low", {31'b0, irq_o}, 32'h0);
    br(A_ST, d);  check("R1 transfer done bit 10", d, 32'h400);
    bw(A_UN, 32'h400);
    check("R5 unmask raises irq", {31'b0, irq_o}, 32'h1);
    bw(A_DM, 32'h400);
    check("R5 domask drops irq", {31'b0, irq_o}, 32'h0);
    bw(A_UN, 32'h400);
    pulse(12'h9C8);
    bw(A_ST, 32'h408);
    br(A_ST, d);  check("R2 w1c clears only written ones", d, 32'h9C0);
    check("R5 irq low after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    clean();
    repeat (3) pulse(12'h002);
    pulse(12'h004);
    br(A_SC, d);  check("R6 src count three", d, 32'h3);
    br(A_SC, d);  check("R8 src count cleared by read", d, 32'h0);
    bw(A_DC, 32'h55);
    br(A_DC, d);  check("R6 dst count write ignored", d, 32'h1);
    br(A_ST, d);  check("R1 done bits 1 and 2", d, 32'h006);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    clean();
    @(negedge clk);
    evt_i = 12'h004;
    repeat (255) @(negedge clk);
    evt_i = '0;
    br(A_ST, d);  check("R7 no error at 255", d & 32'h20, 32'h0);
    pulse(12'h004);
    br(A_ST, d);  check("R7 dst wrap sets bit 5", d & 32'h30, 32'h20);
    br(A_DC, d);  check("R7 dst count wrapped to 0", d, 32'h0);
  endtask

  task automatic t_bad();
    logic [31:0] d;
    clean();
    br(A_BAD, d); check("R9 unmapped read returns zero", d, 32'h0);
    br(A_ST, d);  check("R9 unmapped read sets bit 0", d, 32'h1);
    bw(A_ST, 32'h1);
    bw(A_BAD, 32'hFFFF_FFFF);
    br(A_ST, d);  check("R9 unmapped write sets bit 0", d, 32'h1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    clean();
    pulse(12'h100);
    @(negedge clk);
    evt_i = 12'h100; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 32'h100;
    @(negedge clk);
    evt_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    br(A_ST, d);  check("R10 event wins over clear", d, 32'h100);
    pulse(12'h002);
    pulse(12'h002);
    @(negedge clk);
    evt_i = 12'h002; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_SC;
    #2 d = bus_rdata;
    @(negedge clk);
    evt_i = '0; bus_sel = 1'b0;
    check("R11 read returns old count", d, 32'h2);
    br(A_SC, d);  check("R11 count becomes one", d, 32'h1);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    clean();
    pulse(12'h031);
    br(A_ST, d);  check("R12 input bits 0,4,5 ignored", d, 32'h0);
    br(A_SC, d);  check("R12 counters untouched", d, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mask_ports();
    t_irq();
    t_count();
    t_wrap();
    t_bad();
    t_collide();
    t_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule